// File: doc/BRIEF.md
# Transaction Action List Sequencer

This block steps one coherence transaction through an ordered list of action events. The controller loads the list when it starts a transaction, one event per push, and marks each event as blocking or non-blocking. The sequencer hands the event at the head of the list to the consumer through a valid/ready handshake. An event that leaves work outstanding, such as waiting for a completion acknowledgement, is reported by the consumer on the expect port in the same cycle that it accepts the event. That report raises a pending count on the request side or on the snoop side and enables the named response type on that side.

Arriving responses are matched against the enabled types of their side and decrement that side's count. While any response is still pending, a blocking head event is held back. A non-blocking head event is issued anyway, so that, for example, a tag write can overlap the wait for an acknowledgement. When the list has drained and nothing is pending, the sequencer raises a single-cycle finalize strobe. That strobe also returns the counts and enabled types to their empty state, ready for the next transaction. A response that was not expected raises a sticky error and is not counted.

Top module: `evlist_seq`

## Requirements
- R1: After reset, issue_valid, fin_pulse, rsp_err and push_full are 0, and pend_req and pend_snp are 0.
- R2: Events leave the list in the order they were pushed. Each event leaves with the 5-bit code and the non-blocking flag it was pushed with, and an event is removed on a cycle where both issue_valid and issue_ready are high.
- R3: The list holds 16 events, and push_full is 1 when all 16 are held. A push while push_full is 1 is dropped and leaves the list unchanged, even if an event is issued in the same cycle.
- R4: An event with a non-blocking flag of 0 at the head of the list is not offered (issue_valid is 0) while pend_req or pend_snp is nonzero.
- R5: An event with a non-blocking flag of 1 at the head of the list is offered whatever the pending counts are.
- R6: An expect (expect_side 0 is the request side, 1 is the snoop side) increments that side's pending count by one on the next edge and enables the 3-bit expect_type on that side.
- R7: A response whose type is enabled on its side, arriving while that side's count is nonzero, decrements that side's count by one. The other side's count does not change. An expect and a matching response on the same side in one cycle leave the count unchanged.
- R8: A response whose type is not enabled on its side, or that arrives when its side's count is zero, leaves both counts unchanged and sets rsp_err, which then stays 1 until reset.
- R9: fin_pulse is 1 for exactly one cycle when all of the following hold: at least one event has been pushed since the last finalize or reset, the list is empty, both counts are zero, and neither push_valid nor expect_valid is high. After that cycle, every response type on both sides is disabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Append an event to the list |
| push_code | input | 5 | Event code to append |
| push_nb | input | 1 | Event may issue while responses are pending |
| push_full | output | 1 | List holds 16 events |
| issue_valid | output | 1 | Head event offered to the consumer |
| issue_ready | input | 1 | Consumer takes the head event |
| issue_code | output | 5 | Code of the head event |
| issue_nb | output | 1 | Non-blocking flag of the head event |
| expect_valid | input | 1 | Register one more expected response |
| expect_side | input | 1 | 0 request side, 1 snoop side |
| expect_type | input | 3 | Response type to enable |
| rsp_valid | input | 1 | A response has arrived |
| rsp_side | input | 1 | 0 request side, 1 snoop side |
| rsp_type | input | 3 | Type of the arriving response |
| pend_req | output | 4 | Pending request-side responses |
| pend_snp | output | 4 | Pending snoop-side responses |
| rsp_err | output | 1 | Sticky: an unexpected response was seen |
| fin_pulse | output | 1 | Transaction finished |

## Verification
The assertions take for granted that the consumer never raises a side's pending count beyond 15, the widest value its counter holds. Every stimulus phase keeps within that limit: directed cases register at most a few expectations, and the random phase asks for an expect only while the reference model shows both counts below 13. The assertions also rely on the consumer reporting an expectation in the same cycle in which it takes the event that creates it. The read-hit scenario does exactly that, and the random phase treats expects as independent traffic that the rules above still cover.

// File: rtl/evlist_seq.sv
module evlist_seq #(
  parameter int DEPTH = 16,
  parameter int EVW   = 5,
  parameter int RTW   = 3,
  parameter int CNTW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [EVW-1:0]  push_code,
  input  logic            push_nb,
  output logic            push_full,
  output logic            issue_valid,
  input  logic            issue_ready,
  output logic [EVW-1:0]  issue_code,
  output logic            issue_nb,
  input  logic            expect_valid,
  input  logic            expect_side,
  input  logic [RTW-1:0]  expect_type,
  input  logic            rsp_valid,
  input  logic            rsp_side,
  input  logic [RTW-1:0]  rsp_type,
  output logic [CNTW-1:0] pend_req,
  output logic [CNTW-1:0] pend_snp,
  output logic            rsp_err,
  output logic            fin_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int NT = 1 << RTW;
  localparam logic [CNTW-1:0] CMAX = '1;

  logic [EVW:0]    slots [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW:0]     fill;
  logic            active;
  logic [CNTW-1:0] cnt  [2];
  logic [NT-1:0]   mask [2];

  logic empty, idle, fire, push_ok, rsp_hit;

  assign push_full   = (fill == (AW+1)'(DEPTH));
  assign empty       = (fill == '0);
  assign idle        = (cnt[0] == '0) && (cnt[1] == '0);
  assign issue_code  = slots[rd_ptr][EVW-1:0];
  assign issue_nb    = slots[rd_ptr][EVW];
  assign issue_valid = !empty && (issue_nb || idle);
  assign fire        = issue_valid && issue_ready;
  assign push_ok     = push_valid && !push_full;
  assign fin_pulse   = active && empty && idle && !push_valid && !expect_valid;
  assign rsp_hit     = rsp_valid && mask[rsp_side][rsp_type] && (cnt[rsp_side] != '0);
  assign pend_req    = cnt[0];
  assign pend_snp    = cnt[1];

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= {push_nb, push_code};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      active <= 1'b0;
      rsp_err <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (fire)    rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      fill <= fill + (AW+1)'(push_ok) - (AW+1)'(fire);
      if (fin_pulse)    active <= 1'b0;
      else if (push_ok) active <= 1'b1;
      if (rsp_valid && !rsp_hit) rsp_err <= 1'b1;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic inc, dec;
    assign inc = expect_valid && (expect_side == 1'(s));
    assign dec = rsp_hit && (rsp_side == 1'(s));
    always_ff @(posedge clk) begin
      if (!rst_n || fin_pulse) begin
        cnt[s]  <= '0;
        mask[s] <= '0;
      end else begin
        cnt[s] <= cnt[s] + CNTW'(inc) - CNTW'(dec);
        if (inc) mask[s][expect_type] <= 1'b1;
      end
    end
  end

  assert_full_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_full && push_valid && !fire) |=> push_full);

  assert_expect_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expect_valid && !rsp_valid) |=> (pend_req != '0 || pend_snp != '0));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expect_valid && !rsp_valid) |-> ((expect_side ? pend_snp : pend_req) != CMAX));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> rsp_err);

  assert_fin_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_pulse |=> (pend_req == '0 && pend_snp == '0 && !fin_pulse && !issue_valid));
endmodule

// File: tb/evlist_seq_bench.sv
`timescale 1ns/1ps
module evlist_seq_bench;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_nb = 0, issue_ready = 0;
  logic [4:0] push_code = 0;
  logic expect_valid = 0, expect_side = 0, rsp_valid = 0, rsp_side = 0;
  logic [2:0] expect_type = 0, rsp_type = 0;
  logic push_full, issue_valid, issue_nb, rsp_err, fin_pulse;
  logic [4:0] issue_code;
  logic [3:0] pend_req, pend_snp;

  evlist_seq u_evlist_seq (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, fins = 0;
  bit done = 0, auto_ack = 0;
  int q[$];
  int m_cnt[2];
  bit [7:0] m_mask[2];
  bit m_err, m_act;

  function automatic bit p_iv();
    return q.size() > 0 && (q[0][5] || (m_cnt[0] == 0 && m_cnt[1] == 0));
  endfunction
  function automatic bit p_fin();
    return m_act && q.size() == 0 && m_cnt[0] == 0 && m_cnt[1] == 0 && !push_valid && !expect_valid;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_cnt[0] = 0; m_cnt[1] = 0; m_mask[0] = 0; m_mask[1] = 0; m_err = 0; m_act = 0;
    end else begin
      bit fin, fire, hit;
      int s;
      fin  = p_fin();
      fire = p_iv() && issue_ready;
      if (fin) fins++;
      hit = 0;
      if (rsp_valid) begin
        s = rsp_side;
        hit = m_mask[s][rsp_type] && m_cnt[s] > 0;
        if (!hit) m_err = 1;
      end
      if (fin) begin
        m_cnt[0] = 0; m_cnt[1] = 0; m_mask[0] = 0; m_mask[1] = 0; m_act = 0;
      end else begin
        bit full_pre;
        full_pre = q.size() >= 16;
        if (fire) void'(q.pop_front());
        if (push_valid && !full_pre) begin
          q.push_back({push_nb, push_code}); m_act = 1;
        end
        if (hit) m_cnt[rsp_side]--;
        if (expect_valid) begin
          m_cnt[expect_side]++; m_mask[expect_side][expect_type] = 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit iv;
      iv = p_iv();
      chk((q.size() > 0 && q[0][5]) ? "R5 issue_valid" : "R4 issue_valid", issue_valid, iv);
      if (iv) begin
        chk("R2 issue_code", issue_code, q[0][4:0]);
        chk("R2 issue_nb", issue_nb, q[0][5]);
      end
      chk("R3 push_full", push_full, q.size() >= 16);
      chk("R6 R7 pend_req", pend_req, m_cnt[0]);
      chk("R6 R7 pend_snp", pend_snp, m_cnt[1]);
      chk("R8 rsp_err", rsp_err, m_err);
      chk("R9 fin_pulse", fin_pulse, p_fin());
    end
  end

  task automatic idle_in();
    push_valid = 0; issue_ready = 0; expect_valid = 0; rsp_valid = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_in();
  endtask

  task automatic ack_hook();
    if (auto_ack && issue_valid && issue_ready && issue_code == 5'd5) begin
      expect_valid = 1; expect_side = 0; expect_type = 3'd3;
    end
  endtask

  task automatic push(input logic [4:0] c, input logic nb);
    tick(); push_valid = 1; push_code = c; push_nb = nb;
  endtask

  task automatic rsp(input logic sd, input logic [2:0] t);
    tick(); rsp_valid = 1; rsp_side = sd; rsp_type = t;
  endtask

  task automatic expect_one(input logic sd, input logic [2:0] t);
    tick(); expect_valid = 1; expect_side = sd; expect_type = t;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin tick(); issue_ready = 1; ack_hook(); end
  endtask

  task automatic do_reset();
    tick(); rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  initial begin
    int f0;
    tick(); tick();
    // R1 reset state
    chk("R1 issue_valid", issue_valid, 0);
    chk("R1 fin_pulse", fin_pulse, 0);
    chk("R1 rsp_err", rsp_err, 0);
    chk("R1 push_full", push_full, 0);
    chk("R1 pend", pend_req + pend_snp, 0);
    rst_n = 1;

    // read-hit style list: five blocking events, then one non-blocking
    f0 = fins;
    for (int i = 1; i <= 5; i++) push(5'(i), 0);
    push(5'd6, 1);
    auto_ack = 1;
    drain(10);
    auto_ack = 0;
    chk("R5 nb event issued while ack pending", q.size(), 0);
    chk("R6 one ack pending", pend_req, 1);
    rsp(0, 3'd3);
    tick(); tick();
    chk("R9 one finalize for read hit", fins - f0, 1);

    // R9: stale type no longer accepted after finalize
    rsp(0, 3'd3);
    tick();
    chk("R8 R9 stale response flagged", rsp_err, 1);
    do_reset();

    // R7 sides are independent; R4 blocking hold
    push(5'd9, 0);
    expect_one(1, 3'd2);
    expect_one(0, 3'd1);
    drain(3);
    chk("R4 blocked head held", issue_valid, 0);
    rsp(1, 3'd2);
    tick();
    chk("R7 snp decremented only", pend_snp * 16 + pend_req, 1);
    rsp(0, 3'd2);
    tick();
    chk("R8 type not enabled", rsp_err, 1);
    chk("R8 not counted", pend_req, 1);
    tick(); expect_valid = 1; expect_side = 0; expect_type = 3'd1;
    rsp_valid = 1; rsp_side = 0; rsp_type = 3'd1;
    tick();
    chk("R7 expect and response cancel", pend_req, 1);
    rsp(0, 3'd1);
    drain(3);
    do_reset();

    // R3 overfill
    for (int i = 0; i < 17; i++) push(5'(i + 8), 1'(i & 1));
    tick();
    chk("R3 full after 16", push_full, 1);
    tick(); push_valid = 1; push_code = 5'd31; issue_ready = 1;
    drain(20);
    do_reset();

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      tick();
      push_valid  = ($urandom % 2) == 0;
      push_code   = 5'($urandom);
      push_nb     = ($urandom % 3) == 0;
      issue_ready = ($urandom % 10) < 7;
      if (m_cnt[0] < 13 && m_cnt[1] < 13 && ($urandom % 5) == 0) begin
        expect_valid = 1; expect_side = 1'($urandom); expect_type = 3'($urandom % 4);
      end
      if (($urandom % 4) == 0) begin
        rsp_valid = 1; rsp_side = 1'($urandom); rsp_type = 3'($urandom % 4);
      end
      if (i % 500 == 499) begin idle_in(); rst_n = 0; end
      else rst_n = 1;
    end
    drain(40);
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule